// File: doc/BRIEF.md
# Merged Status Interrupt Controller

This block folds three status events from an Ethernet controller into one interrupt line: a change of the link-OK level, a rollover reported by the statistics counters, and a transmit error. Each source has an enable bit in a CPU-writable control word. When a source fires while its enable is set, a pending flag for that source is latched. The merged interrupt is raised while any source is both pending and enabled.

Each source is cleared in its own way. A link-change flag is cleared by writing its enable to zero. A counter-rollover flag is cleared by a read strobe on the counter register. A transmit-error flag is cleared either by the CPU writing 1 to the transmit-enable bit or by writing the transmit-error enable to zero. A transmit error is a fall of the transmit-enable status while transmit-success is low. The link-OK input is asynchronous, so it passes through a synchronizer before transitions are detected.

Top module: `evt_irq_merge`

## Requirements
- R1: After reset, all three enables, all three pending flags (`pend[0]` link, `pend[1]` counter, `pend[2]` transmit) and `irq` are 0.
- R2: A `cfg_wr` pulse loads the enables from `cfg_wdata` bit 7 (link, `en_q[0]`), bit 6 (counter, `en_q[1]`) and bit 5 (transmit, `en_q[2]`). All other bits of the word have no effect.
- R3: With the link enable set, any rise or fall of `link_ok` sets `pend[0]`. The flag is visible after the third rising clock edge following the change and not before. With the enable clear, a change sets nothing.
- R4: A `cfg_wr` with bit 7 at 0 clears `pend[0]`.
- R5: With the counter enable set, a `ctr_roll` pulse sets `pend[1]` at the next edge. A `ctr_rd` pulse clears it. With the enable clear, `ctr_roll` sets nothing.
- R6: With the transmit enable set, a 1-to-0 change of `txen` in a cycle where `tx_suc` is 0 sets `pend[2]` at that edge. A fall of `txen` while `tx_suc` is 1 sets nothing.
- R7: `pend[2]` is cleared by a `txen_wr` pulse with `txen_wdata` = 1, or by a `cfg_wr` with bit 5 at 0. A `txen_wr` with `txen_wdata` = 0 leaves it set.
- R8: `irq` is high exactly while some source is both pending and enabled. A pending counter flag whose enable was cleared keeps `pend[1]` high but drops `irq`.
- R9: When an event and its acknowledge arrive in the same cycle, the event wins and the flag is set or stays set.
- R10: A `link_ok` level already present when reset is released is not treated as a transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_ok | input | 1 | Asynchronous link-good level |
| ctr_roll | input | 1 | One-cycle pulse: a statistics counter rolled over |
| ctr_rd | input | 1 | One-cycle pulse: CPU read of the counter register |
| txen | input | 1 | Transmit-enable status level |
| tx_suc | input | 1 | Transmit-success status level |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | CTL_W | Control word write data |
| txen_wr | input | 1 | CPU write strobe to the transmit-enable bit |
| txen_wdata | input | 1 | Value written to the transmit-enable bit |
| irq | output | 1 | Merged interrupt |
| pend | output | 3 | Pending flags: [0] link, [1] counter, [2] transmit |
| en_q | output | 3 | Current enables: [0] link, [1] counter, [2] transmit |

## Verification
The bench builds the block with its defaults: a 16-bit control word, enables at bits 7, 6 and 5, and a two-stage synchronizer. The link latency checks count exactly these two stages plus one detect edge. That makes both the "not yet at two edges" and "set at three edges" cases reachable, and also the reset case where the synchronizer fills with a high level. Writing the full 16-bit word lets the bench set every bit outside the three enables and confirm that none of them has an effect.

// File: rtl/evt_irq_pkg.sv
// Package: shared source indices and vector type for the merged interrupt.
// Assumes exactly three sources in a fixed order: link, counter, transmit.
package evt_irq_pkg;
    localparam int NSRC = 3;

    typedef enum int {
        SRC_LINK = 0,
        SRC_CTR  = 1,
        SRC_TXE  = 2
    } src_e;

    typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/lvl_sync.sv
// Multi-stage synchronizer for an asynchronous level.
// Also produces a valid flag that rises once the chain has been filled
// since reset, so that downstream logic ignores the reset-time contents.
// Assumes STAGES >= 2.
module lvl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q,
    output logic q_valid
);
    logic [STAGES-1:0] chain;
    logic [STAGES-1:0] fill;

    // Shift the level and a fill marker through the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            fill  <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
            fill  <= {fill[STAGES-2:0], 1'b1};
        end
    end

    assign q       = chain[STAGES-1];
    assign q_valid = fill[STAGES-1];
endmodule

// File: rtl/edge_watch.sv
// Detects either transition of a synchronized level.
// A transition is reported only when both the current and the previous
// samples are valid, so the first valid sample never counts as a change.
module edge_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic lvl_valid,
    output logic toggle
);
    logic prev;
    logic prev_valid;

    // Remember the previous synchronized sample and whether it was valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev       <= 1'b0;
            prev_valid <= 1'b0;
        end else begin
            prev       <= lvl;
            prev_valid <= lvl_valid;
        end
    end

    assign toggle = lvl_valid && prev_valid && (lvl != prev);
endmodule

// File: rtl/txerr_watch.sv
// Flags a transmit error: the transmit-enable status falls in a cycle
// where transmit-success is low. Assumes both inputs are synchronous.
module txerr_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic txen,
    input  logic tx_suc,
    output logic txerr
);
    logic txen_prev;

    // Keep last cycle's transmit-enable to find its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) txen_prev <= 1'b0;
        else        txen_prev <= txen;
    end

    assign txerr = txen_prev && !txen && !tx_suc;
endmodule

// File: rtl/enable_reg.sv
// Holds the three source enables taken from fixed bits of a control word.
// Also reports, per source, that the current write clears its enable;
// the top module uses this as an acknowledge.
module enable_reg
    import evt_irq_pkg::*;
#(
    parameter int CTL_W    = 16,
    parameter int LINK_BIT = 7,
    parameter int CTR_BIT  = 6,
    parameter int TXE_BIT  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CTL_W-1:0] wdata,
    output src_vec_t         en,
    output src_vec_t         clr_req
);
    src_vec_t   wr_bits;
    logic       unused_bits;

    // Pick the enable bits out of the written word, in source order.
    always_comb begin
        wr_bits           = '0;
        wr_bits[SRC_LINK] = wdata[LINK_BIT];
        wr_bits[SRC_CTR]  = wdata[CTR_BIT];
        wr_bits[SRC_TXE]  = wdata[TXE_BIT];
    end

    assign unused_bits = ^wdata;

    // Load the enables on a write; they stay as they are otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)  en <= '0;
        else if (wr) en <= wr_bits;
    end

    assign clr_req = wr ? ~wr_bits : '0;
endmodule

// File: rtl/pend_bank.sv
// Bank of pending flags. Each flag is set by its event and cleared by its
// acknowledge; if both come in the same cycle, the event wins.
module pend_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] ack,
    output logic [N-1:0] pend
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // One sticky flag with event priority over acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n)      pend[i] <= 1'b0;
            else if (evt[i]) pend[i] <= 1'b1;
            else if (ack[i]) pend[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/evt_irq_merge.sv
// Merged status interrupt: gathers link change, counter rollover and
// transmit error into per-source pending flags. Drives one interrupt
// while any source is both pending and enabled.
// Assumes every input except link_ok is synchronous to clk.
module evt_irq_merge
    import evt_irq_pkg::*;
#(
    parameter int CTL_W       = 16,
    parameter int LINK_BIT    = 7,
    parameter int CTR_BIT     = 6,
    parameter int TXE_BIT     = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_ok,
    input  logic             ctr_roll,
    input  logic             ctr_rd,
    input  logic             txen,
    input  logic             tx_suc,
    input  logic             cfg_wr,
    input  logic [CTL_W-1:0] cfg_wdata,
    input  logic             txen_wr,
    input  logic             txen_wdata,
    output logic             irq,
    output logic [NSRC-1:0]  pend,
    output logic [NSRC-1:0]  en_q
);
    logic     link_s;
    logic     link_s_valid;
    logic     link_evt;
    logic     txe_evt;
    src_vec_t en_clr;
    src_vec_t raw_evt;
    src_vec_t gated_evt;
    src_vec_t ack;

    lvl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d       (link_ok),
        .q       (link_s),
        .q_valid (link_s_valid)
    );

    edge_watch u_link_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl       (link_s),
        .lvl_valid (link_s_valid),
        .toggle    (link_evt)
    );

    txerr_watch u_txerr (
        .clk    (clk),
        .rst_n  (rst_n),
        .txen   (txen),
        .tx_suc (tx_suc),
        .txerr  (txe_evt)
    );

    enable_reg #(
        .CTL_W    (CTL_W),
        .LINK_BIT (LINK_BIT),
        .CTR_BIT  (CTR_BIT),
        .TXE_BIT  (TXE_BIT)
    ) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cfg_wr),
        .wdata   (cfg_wdata),
        .en      (en_q),
        .clr_req (en_clr)
    );

    // Collect raw events and each source's own acknowledge rule.
    always_comb begin
        raw_evt           = '0;
        raw_evt[SRC_LINK] = link_evt;
        raw_evt[SRC_CTR]  = ctr_roll;
        raw_evt[SRC_TXE]  = txe_evt;

        ack               = '0;
        ack[SRC_LINK]     = en_clr[SRC_LINK];
        ack[SRC_CTR]      = ctr_rd;
        ack[SRC_TXE]      = en_clr[SRC_TXE] | (txen_wr & txen_wdata);
    end

    // An event counts only while its enable is already set.
    assign gated_evt = raw_evt & en_q;

    pend_bank #(.N(NSRC)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (gated_evt),
        .ack   (ack),
        .pend  (pend)
    );

    assign irq = |(pend & en_q);
endmodule

// File: rtl/evt_irq_merge_chk.sv
// Checker for the merged status interrupt, bound to every instance.
// It observes the top-level ports and the internal detected-event signals.
module evt_irq_merge_chk #(
    parameter int CTL_W    = 16,
    parameter int LINK_BIT = 7,
    parameter int CTR_BIT  = 6,
    parameter int TXE_BIT  = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             link_evt,
    input logic             txe_evt,
    input logic             ctr_roll,
    input logic             ctr_rd,
    input logic             cfg_wr,
    input logic [CTL_W-1:0] cfg_wdata,
    input logic             txen_wr,
    input logic             txen_wdata,
    input logic             irq,
    input logic [2:0]       pend,
    input logic [2:0]       en_q
);
    a_r2_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(en_q));

    a_r3_link_set: assert property (@(posedge clk) disable iff (!rst_n)
        (link_evt && en_q[0]) |=> pend[0]);

    a_r4_link_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_wdata[LINK_BIT] && !(link_evt && en_q[0])) |=> !pend[0]);

    a_r5_ctr_set: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_roll && en_q[1]) |=> pend[1]);

    a_r5_ctr_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_rd && !(ctr_roll && en_q[1])) |=> !pend[1]);

    a_r6_tx_set: assert property (@(posedge clk) disable iff (!rst_n)
        (txe_evt && en_q[2]) |=> pend[2]);

    a_r7_tx_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (((txen_wr && txen_wdata) || (cfg_wr && !cfg_wdata[TXE_BIT]))
         && !(txe_evt && en_q[2])) |=> !pend[2]);

    a_r8_irq_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((pend & en_q) != 3'b000));

    a_r8_ctr_drives_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[1] && en_q[1]) |-> irq);

    a_r10_link_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend[0] && !(link_evt && en_q[0])) |=> !pend[0]);

    a_r1_pend_onehot_free: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n)) |-> (pend == 3'b000 && en_q == 3'b000));
endmodule

bind evt_irq_merge evt_irq_merge_chk #(
    .CTL_W    (CTL_W),
    .LINK_BIT (LINK_BIT),
    .CTR_BIT  (CTR_BIT),
    .TXE_BIT  (TXE_BIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .link_evt   (link_evt),
    .txe_evt    (txe_evt),
    .ctr_roll   (ctr_roll),
    .ctr_rd     (ctr_rd),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_wdata),
    .txen_wr    (txen_wr),
    .txen_wdata (txen_wdata),
    .irq        (irq),
    .pend       (pend),
    .en_q       (en_q)
);

// File: tb/tb_evt_irq_merge.sv
// Directed bench for the merged status interrupt: one task per scenario.
module tb_evt_irq_merge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_ok = 1'b0;
    logic        ctr_roll = 1'b0;
    logic        ctr_rd = 1'b0;
    logic        txen = 1'b0;
    logic        tx_suc = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        txen_wr = 1'b0;
    logic        txen_wdata = 1'b0;
    logic        irq;
    logic [2:0]  pend;
    logic [2:0]  en_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    evt_irq_merge dut (
        .clk(clk), .rst_n(rst_n), .link_ok(link_ok), .ctr_roll(ctr_roll),
        .ctr_rd(ctr_rd), .txen(txen), .tx_suc(tx_suc), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .txen_wr(txen_wr), .txen_wdata(txen_wdata),
        .irq(irq), .pend(pend), .en_q(en_q)
    );

    always #5 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic link_lvl);
        rst_n = 1'b0;
        link_ok = link_lvl;
        ctr_roll = 0; ctr_rd = 0; txen = 0; tx_suc = 0;
        cfg_wr = 0; cfg_wdata = '0; txen_wr = 0; txen_wdata = 0;
        ticks(3);
        rst_n = 1'b1;
    endtask

    task automatic write_cfg(input logic [15:0] w);
        cfg_wr = 1'b1; cfg_wdata = w;
        tick();
        cfg_wr = 1'b0; cfg_wdata = '0;
    endtask

    task automatic t_reset_state();
        do_reset(1'b0);
        check("R1 enables", {5'b0, en_q}, 8'h0);
        check("R1 pend", {5'b0, pend}, 8'h0);
        check("R1 irq", {7'b0, irq}, 8'h0);
    endtask

    task automatic t_cfg_bits();
        write_cfg(16'hFF1F);
        check("R2 other bits ignored", {5'b0, en_q}, 8'h0);
        write_cfg(16'h00E0);
        check("R2 all enables", {5'b0, en_q}, 8'h7);
        write_cfg(16'h0040);
        check("R2 counter only", {5'b0, en_q}, 8'h2);
        write_cfg(16'h0000);
    endtask

    task automatic t_link();
        write_cfg(16'h0080);
        link_ok = 1'b1;
        ticks(2);
        check("R3 rise not yet", {7'b0, pend[0]}, 8'h0);
        tick();
        check("R3 rise pending", {7'b0, pend[0]}, 8'h1);
        check("R8 irq from link", {7'b0, irq}, 8'h1);
        write_cfg(16'h0000);
        check("R4 clear enable acks", {7'b0, pend[0]}, 8'h0);
        check("R8 irq low after ack", {7'b0, irq}, 8'h0);
        write_cfg(16'h0080);
        link_ok = 1'b0;
        ticks(3);
        check("R3 fall pending", {7'b0, pend[0]}, 8'h1);
        write_cfg(16'h0000);
        link_ok = 1'b1;
        ticks(5);
        check("R3 disabled change ignored", {7'b0, pend[0]}, 8'h0);
    endtask

    task automatic t_counter();
        write_cfg(16'h0040);
        ctr_roll = 1'b1; tick(); ctr_roll = 1'b0;
        check("R5 rollover pending", {7'b0, pend[1]}, 8'h1);
        check("R8 irq from counter", {7'b0, irq}, 8'h1);
        write_cfg(16'h0000);
        check("R8 pend kept when disabled", {7'b0, pend[1]}, 8'h1);
        check("R8 irq off when disabled", {7'b0, irq}, 8'h0);
        ctr_rd = 1'b1; tick(); ctr_rd = 1'b0;
        check("R5 read acks", {7'b0, pend[1]}, 8'h0);
        ctr_roll = 1'b1; tick(); ctr_roll = 1'b0;
        check("R5 disabled rollover ignored", {7'b0, pend[1]}, 8'h0);
        write_cfg(16'h0040);
        ctr_roll = 1'b1; tick(); ctr_roll = 1'b0;
        ctr_roll = 1'b1; ctr_rd = 1'b1; tick(); ctr_roll = 1'b0; ctr_rd = 1'b0;
        check("R9 event beats ack", {7'b0, pend[1]}, 8'h1);
        ctr_rd = 1'b1; tick(); ctr_rd = 1'b0;
        check("R9 ack alone clears", {7'b0, pend[1]}, 8'h0);
        write_cfg(16'h0000);
    endtask

    task automatic tx_fall(input logic suc);
        txen = 1'b1; tick();
        txen = 1'b0; tx_suc = suc; tick();
        tx_suc = 1'b0;
    endtask

    task automatic t_transmit();
        write_cfg(16'h0020);
        tx_fall(1'b1);
        check("R6 success fall ignored", {7'b0, pend[2]}, 8'h0);
        tx_fall(1'b0);
        check("R6 error pending", {7'b0, pend[2]}, 8'h1);
        check("R8 irq from transmit", {7'b0, irq}, 8'h1);
        txen_wr = 1'b1; txen_wdata = 1'b0; tick(); txen_wr = 1'b0;
        check("R7 write 0 no ack", {7'b0, pend[2]}, 8'h1);
        txen_wr = 1'b1; txen_wdata = 1'b1; tick(); txen_wr = 1'b0; txen_wdata = 1'b0;
        check("R7 write 1 acks", {7'b0, pend[2]}, 8'h0);
        tx_fall(1'b0);
        check("R6 error again", {7'b0, pend[2]}, 8'h1);
        write_cfg(16'h0000);
        check("R7 clear enable acks", {7'b0, pend[2]}, 8'h0);
    endtask

    task automatic t_reset_link_high();
        do_reset(1'b1);
        write_cfg(16'h0080);
        ticks(5);
        check("R10 reset level not a change", {7'b0, pend[0]}, 8'h0);
        write_cfg(16'h0000);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_cfg_bits();
        t_link();
        t_counter();
        t_transmit();
        t_reset_link_high();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule